// File: doc/BRIEF.md
# RGB Bit-Plane Separator

This block turns a stream of 24-bit true-colour pixels into bit planes. It groups eight consecutive valid pixels. For each group it emits eight 24-bit words, one per bit weight. A word holds the bits of one weight from all eight pixels, for blue, green and red side by side. The stage that follows writes bit planes into a field-ordered frame store, so that a display driver can read whole planes later. Each output word comes with a valid flag and a 3-bit weight index, which the write stage uses to place it.

Inside, the block is an 8×8 bit-matrix transpose per colour with two banks. A collector gathers the pixels of the current group. A hold bank keeps the previous group while its planes are read out. A small state machine walks through the weights. Its states are `SEQ_IDLE` (no plane being emitted) and `SEQ_EMIT` (one plane per clock). Its transitions are:
- load: `SEQ_IDLE` to `SEQ_EMIT` when a group completes.
- step: `SEQ_EMIT` to itself while the weight is above zero.
- chain: `SEQ_EMIT` to itself at weight 0 when the next group completes in the same cycle.
- drain: `SEQ_EMIT` to `SEQ_IDLE` at weight 0 with no new group.

The plane count must not exceed the group size (`CH_W <= GRP`). Otherwise a new group could arrive before the previous one has been read out.

Top module: `rgb_plane_splitter`

## Requirements
- R1: After reset, `plane_valid` is low and `plane_word` is zero until a full group of eight valid pixels has been taken in.
- R2: In the word for weight p, bit c*8+i is bit p of colour field c of pixel i of the group. Pixels are numbered 0 to 7 in order of acceptance. The colour fields are c=0 blue (`pix_data[7:0]`), c=1 green (`[15:8]`) and c=2 red (`[23:16]`).
- R3: The eight words of a group appear on eight consecutive cycles with `plane_weight` equal to 7, 6, ... 0, in that order.
- R4: The weight-7 word of a group appears in the cycle right after the cycle in which the eighth pixel of the group is presented with `pix_valid` high.
- R5: A cycle with `pix_valid` low is ignored, whatever `pix_data` holds. A partial group is kept across such cycles, and no word is emitted before the group is complete.
- R6: A new group is taken in while the previous group is being emitted. With an unbroken input stream, the weight-0 word of one group is followed in the next cycle by the weight-7 word of the next group, with no gap.
- R7: `plane_word` is zero in every cycle in which `plane_valid` is low.
- R8: If pixels 0 to 6 of a group are zero and pixel 7 has red field 02h, the weight-1 word is 800000h and the other seven words are zero.
- R9: A reset in the middle of a group discards the pixels taken in so far. The next eight valid pixels form a fresh group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_valid | input | 1 | High when `pix_data` carries a pixel |
| pix_data | input | 24 | Pixel: red [23:16], green [15:8], blue [7:0] |
| plane_valid | output | 1 | High when `plane_word` carries a bit plane |
| plane_word | output | 24 | Same-weight bits of eight pixels: red [23:16], green [15:8], blue [7:0] |
| plane_weight | output | 3 | Bit weight of the current word |

## Verification
The bench builds the block with the default parameters, eight pixels per group and eight bits per colour. With these values a group takes exactly as many cycles to gather as to emit. This brings the seamless hand-over from weight 0 of one group to weight 7 of the next within reach of a back-to-back stream. It also brings the chain transition of the state machine within reach. The directed cases cover:
- the single-bit example;
- walking-bit patterns that expose any swap of pixel, colour or weight;
- stalls with garbage on the data bus;
- a reset in the middle of a group.

// File: rtl/rps_pkg.sv
package rps_pkg;
    localparam int NCOL = 3;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_EMIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/rps_collector.sv
module rps_collector
    import rps_pkg::*;
#(
    parameter int GRP  = 8,
    parameter int CH_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pix_valid,
    input  logic [NCOL*CH_W-1:0]      pix_data,
    output logic                      group_done,
    output logic [GRP*NCOL*CH_W-1:0]  group_flat
);
    localparam int PIX_W = NCOL * CH_W;
    localparam int CNT_W = (GRP > 2) ? $clog2(GRP) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP - 1);

    logic [CNT_W-1:0] fill_cnt;
    logic [PIX_W-1:0] slot [GRP-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (pix_valid) begin
            if (fill_cnt == LAST) begin
                fill_cnt <= '0;
            end else begin
                fill_cnt <= fill_cnt + 1'b1;
            end
        end
    end

    assign group_done = pix_valid && (fill_cnt == LAST);

    for (genvar k = 0; k < GRP - 1; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[k] <= '0;
            end else if (pix_valid && (fill_cnt == CNT_W'(k))) begin
                slot[k] <= pix_data;
            end
        end
        assign group_flat[k*PIX_W +: PIX_W] = slot[k];
    end

    assign group_flat[(GRP-1)*PIX_W +: PIX_W] = pix_data;
endmodule

// File: rtl/rps_sequencer.sv
module rps_sequencer
    import rps_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  group_done,
    output logic                  emit,
    output logic [$clog2(CH_W)-1:0] weight
);
    localparam int WGT_W = $clog2(CH_W);
    localparam logic [WGT_W-1:0] TOP = WGT_W'(CH_W - 1);

    seq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: begin
                if (group_done) begin
                    state_nx = SEQ_EMIT;
                end
            end
            SEQ_EMIT: begin
                if ((weight == '0) && !group_done) begin
                    state_nx = SEQ_IDLE;
                end
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            weight <= '0;
        end else if (group_done) begin
            weight <= TOP;
        end else if ((state == SEQ_EMIT) && (weight != '0)) begin
            weight <= weight - 1'b1;
        end
    end

    assign emit = (state == SEQ_EMIT);
endmodule

// File: rtl/rps_extract.sv
module rps_extract
    import rps_pkg::*;
#(
    parameter int GRP  = 8,
    parameter int CH_W = 8
) (
    input  logic [GRP*NCOL*CH_W-1:0]  hold_flat,
    input  logic [$clog2(CH_W)-1:0]   weight,
    input  logic                      enable,
    output logic [NCOL*GRP-1:0]       word
);
    localparam int PIX_W = NCOL * CH_W;

    logic [NCOL*GRP-1:0] raw;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        for (genvar i = 0; i < GRP; i++) begin : g_pix
            logic [CH_W-1:0] field;
            assign field = hold_flat[i*PIX_W + c*CH_W +: CH_W];
            assign raw[c*GRP + i] = field[weight];
        end
    end

    assign word = enable ? raw : '0;
endmodule

// File: rtl/rgb_plane_splitter.sv
module rgb_plane_splitter
    import rps_pkg::*;
#(
    parameter int GRP  = 8,
    parameter int CH_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pix_valid,
    input  logic [NCOL*CH_W-1:0]      pix_data,
    output logic                      plane_valid,
    output logic [NCOL*GRP-1:0]       plane_word,
    output logic [$clog2(CH_W)-1:0]   plane_weight
);
    localparam int GRP_BITS = GRP * NCOL * CH_W;

    logic                   group_done;
    logic [GRP_BITS-1:0]    group_flat;
    logic [GRP_BITS-1:0]    hold_flat;
    logic                   emit;
    logic [$clog2(CH_W)-1:0] weight;

    rps_collector #(.GRP(GRP), .CH_W(CH_W)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .group_done (group_done),
        .group_flat (group_flat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_flat <= '0;
        end else if (group_done) begin
            hold_flat <= group_flat;
        end
    end

    rps_sequencer #(.CH_W(CH_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .group_done (group_done),
        .emit       (emit),
        .weight     (weight)
    );

    rps_extract #(.GRP(GRP), .CH_W(CH_W)) u_extract (
        .hold_flat (hold_flat),
        .weight    (weight),
        .enable    (emit),
        .word      (plane_word)
    );

    assign plane_valid  = emit;
    assign plane_weight = weight;
endmodule

// File: rtl/rps_checker.sv
module rps_checker
    import rps_pkg::*;
#(
    parameter int GRP  = 8,
    parameter int CH_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pix_valid,
    input  logic                     plane_valid,
    input  logic [NCOL*GRP-1:0]      plane_word,
    input  logic [$clog2(CH_W)-1:0]  plane_weight
);
    localparam int WGT_W = $clog2(CH_W);
    localparam int CNT_W = (GRP > 2) ? $clog2(GRP) : 1;
    localparam logic [WGT_W-1:0] TOP  = WGT_W'(CH_W - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP - 1);

    logic [CNT_W-1:0] seen;
    logic             grp_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (pix_valid) begin
            seen <= (seen == LAST) ? '0 : seen + 1'b1;
        end
    end

    assign grp_end = pix_valid && (seen == LAST);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !plane_valid);

    assert_weight_desc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_valid && plane_weight != '0) |=>
        (plane_valid && plane_weight == WGT_W'($past(plane_weight) - 1'b1)));

    assert_first_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end |=> (plane_valid && plane_weight == TOP));

    assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_valid && plane_weight == '0 && !grp_end) |=> !plane_valid);

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !plane_valid |-> (plane_word == '0));
endmodule

bind rgb_plane_splitter rps_checker #(.GRP(GRP), .CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .plane_valid  (plane_valid),
    .plane_word   (plane_word),
    .plane_weight (plane_weight)
);

// File: tb/sim_rgb_plane_splitter.sv
`timescale 1ns/1ps
module sim_rgb_plane_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic        plane_valid;
    logic [23:0] plane_word;
    logic [2:0]  plane_weight;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [23:0] grp [8];
    logic [23:0] grp2 [8];
    logic [23:0] cap_w [64];
    logic [2:0]  cap_g [64];
    int          cap_c [64];
    int          cap_n = 0;
    int          last_cyc = 0;

    always #4 clk = ~clk;

    rgb_plane_splitter #(.GRP(8), .CH_W(8)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_valid    (pix_valid),
        .pix_data     (pix_data),
        .plane_valid  (plane_valid),
        .plane_word   (plane_word),
        .plane_weight (plane_weight)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && plane_valid && cap_n < 64) begin
            cap_w[cap_n] = plane_word;
            cap_g[cap_n] = plane_weight;
            cap_c[cap_n] = cyc;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] plane_of(input logic [23:0] g [8], input int p);
        logic [23:0] w = '0;
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < 8; i++)
                w[c*8+i] = g[i][c*8+p];
        return w;
    endfunction

    task automatic idle(input int n);
        pix_valid = 1'b0;
        repeat (n) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic send_group(input logic [23:0] g [8], input int gap);
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < gap; s++) begin
                pix_valid = 1'b0;
                pix_data = 24'($urandom);
                @(posedge clk); #1;
            end
            pix_valid = 1'b1;
            pix_data = g[i];
            last_cyc = cyc;
            @(posedge clk); #1;
        end
        pix_valid = 1'b0;
    endtask

    task automatic verify(input logic [23:0] g [8], input int base, input string req);
        for (int k = 0; k < 8; k++) begin
            check(cap_g[base+k] == 3'(7-k), "R3 weight order", 32'(cap_g[base+k]), 32'(7-k));
            check(cap_w[base+k] == plane_of(g, 7-k), req, 32'(cap_w[base+k]),
                  32'(plane_of(g, 7-k)));
            check(cap_c[base+k] == cap_c[base] + k, "R3 consecutive", 32'(cap_c[base+k]),
                  32'(cap_c[base] + k));
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(plane_valid == 1'b0, "R1 valid after reset", 32'(plane_valid), 0);
        check(plane_word == '0, "R1 word after reset", 32'(plane_word), 0);
        @(posedge clk); #1;
    endtask

    task automatic t_example();
        for (int i = 0; i < 8; i++) grp[i] = '0;
        grp[7] = 24'h020000;
        cap_n = 0;
        send_group(grp, 0);
        idle(10);
        check(cap_n == 8, "R8 word count", 32'(cap_n), 8);
        for (int k = 0; k < 8; k++)
            check(cap_w[k] == ((7-k) == 1 ? 24'h800000 : 24'h0), "R8 example word",
                  32'(cap_w[k]), (7-k) == 1 ? 32'h800000 : 0);
        check(cap_c[0] == last_cyc + 1, "R4 latency", 32'(cap_c[0]), 32'(last_cyc + 1));
        check(plane_word == '0 && !plane_valid, "R7 idle word", 32'(plane_word), 0);
    endtask

    task automatic t_patterns();
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 8; i++)
                grp[i] = {8'(1 << ((i + r) % 8)), ~8'(1 << i), 8'(i*37 + r*91 + 5)};
            cap_n = 0;
            send_group(grp, 0);
            idle(10);
            check(cap_n == 8, "R2 word count", 32'(cap_n), 8);
            verify(grp, 0, "R2 layout");
            check(cap_c[0] == last_cyc + 1, "R4 latency", 32'(cap_c[0]), 32'(last_cyc + 1));
        end
    endtask

    task automatic t_stall();
        for (int i = 0; i < 8; i++) grp[i] = 24'(32'h5a3c0f * (i + 1) ^ 32'h00ff11);
        cap_n = 0;
        send_group(grp, 2);
        check(cap_n == 0, "R5 no early word", 32'(cap_n), 0);
        idle(10);
        check(cap_n == 8, "R5 word count", 32'(cap_n), 8);
        verify(grp, 0, "R5 stalled group");
        check(cap_c[0] == last_cyc + 1, "R4 latency after stall", 32'(cap_c[0]),
              32'(last_cyc + 1));
    endtask

    task automatic t_back2back();
        for (int i = 0; i < 8; i++) begin
            grp[i]  = 24'(32'h123456 + i * 32'h0f1e2d);
            grp2[i] = ~24'(32'h654321 + i * 32'h020408);
        end
        cap_n = 0;
        send_group(grp, 0);
        pix_valid = 1'b1;
        send_group(grp2, 0);
        idle(12);
        check(cap_n == 16, "R6 word count", 32'(cap_n), 16);
        verify(grp, 0, "R6 first group");
        verify(grp2, 8, "R6 second group");
        check(cap_c[8] == cap_c[7] + 1, "R6 no gap", 32'(cap_c[8]), 32'(cap_c[7] + 1));
    endtask

    task automatic t_midreset();
        for (int i = 0; i < 3; i++) begin
            pix_valid = 1'b1;
            pix_data = 24'hffffff;
            @(posedge clk); #1;
        end
        pix_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) begin
            @(posedge clk); #1;
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(plane_valid == 1'b0, "R9 quiet after reset", 32'(plane_valid), 0);
        @(posedge clk); #1;
        for (int i = 0; i < 8; i++) grp[i] = 24'(i * 32'h010203);
        cap_n = 0;
        send_group(grp, 0);
        idle(10);
        check(cap_n == 8, "R9 word count", 32'(cap_n), 8);
        verify(grp, 0, "R9 fresh group");
    endtask

    initial begin
        t_reset();
        t_example();
        t_patterns();
        t_stall();
        t_back2back();
        t_midreset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule